// File: doc/BRIEF.md
# HDLC Channel FIFO and Interrupt Status Unit

This block serves one HDLC channel between a byte-level framer and a host. Bytes from the framer enter a receive FIFO, and the host pops them from there. The host fills a transmit FIFO, and the framer draws bytes from it whenever it asks for one. Bit-level framing (flags, stuffing, CRC) lives in the framer. Here the framer is seen only as byte strobes, a last-byte marker and a "last bit shifted out" pulse.

Four events are collected in a status register that clears when read:
- a pool of bytes has built up inside a frame still being received;
- a received byte was lost;
- the transmitter ran dry;
- the transmitter went idle with nothing left to send.

A mask decides which of these events drive the interrupt line. Each completed receive frame also produces a status strobe that says whether that frame lost data. After a transmit underrun, the transmit side locks itself out until the host reads the status register.

Two state machines carry the sequencing:
- The receive tracker has the states RX_GAP (between frames) and RX_FRAME (frame open). A byte that is not the last moves it from RX_GAP to RX_FRAME. The last byte moves it from RX_FRAME back to RX_GAP.
- The transmit controller has the states TX_IDLE, TX_SEND and TX_LOCKED:
  - TX_IDLE goes to TX_SEND when a byte that is not the last is granted.
  - TX_SEND goes back to TX_IDLE when the last byte is granted.
  - Either state goes to TX_LOCKED on an underrun.
  - TX_LOCKED goes back to TX_IDLE on the clock edge of a status read.

Top module: `hdlc_fifo_stat`

## Requirements
- R1: Status bits are: bit 3 receive overflow, bit 2 all sent, bit 1 transmit underrun, bit 0 receive pool. `sts_q` shows the register. A cycle with `sts_rd`=1 returns the current bits and clears them at that clock edge. An event occurring in the same cycle as the read is kept and shows from the next cycle.
- R2: Each stored byte that completes a further 32 stored bytes of the current frame sets bit 0 on the next cycle, unless that byte carries `rx_byte_last`. The per-frame count restarts after every last byte.
- R3: The receive FIFO holds 64 bytes. A byte strobed while it is full is discarded and sets bit 3 on the next cycle, even if a pop happens in that cycle. Bytes arriving once there is space again are stored. `rx_data` is the oldest byte and `rx_level` is the fill level.
- R4: In the cycle after a byte with `rx_byte_last`=1, `rx_fstat_vld` is 1 for one cycle. At that point `rx_fstat_ovf` is 1 exactly when a byte of that frame, including the last one, was lost.
- R5: When `tx_req`=1 and the transmit FIFO is not empty, `tx_byte_vld`=1 in the same cycle and `tx_byte` is the oldest byte, which is removed. `tx_last`=1 when that byte is the only one left and a message end (`tx_msg_end`) is pending.
- R6: When `tx_req`=1, the transmit FIFO is empty and no message end is pending, `tx_abort`=1 in the same cycle. Bit 1 is set on the next cycle, the transmit FIFO is emptied and the transmit side locks.
- R7: While `tx_locked`=1, the following have no effect: `tx_push`, `tx_req`, `tx_msg_end` and `tx_done`. The transmit FIFO stays empty. The lock ends at the clock edge of a status read.
- R8: `tx_done`=1 with `hdlc_mode`=1, the transmit FIFO empty and no lock sets bit 2. With `hdlc_mode`=0 it sets nothing.
- R9: `irq` is the OR of the status bits whose mask bit is 0. A set mask bit hides its status bit from `irq` but does not stop that bit from being set. `mask_wr` loads the mask.
- R10: After reset the following hold: status 0, mask 0, both FIFOs empty, no lock, `irq`=0, `rx_fstat_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdlc_mode | input | 1 | Enables the all-sent event |
| rx_byte_vld | input | 1 | Framer delivers a received byte |
| rx_byte_last | input | 1 | The delivered byte ends its frame |
| rx_byte | input | 8 | Received byte |
| rx_pop | input | 1 | Host removes the oldest receive byte |
| rx_data | output | 8 | Oldest receive byte |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 7 | Receive FIFO fill level |
| rx_fstat_vld | output | 1 | Frame status strobe |
| rx_fstat_ovf | output | 1 | Finished frame lost data |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte to write |
| tx_msg_end | input | 1 | Host command: frame data complete |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 7 | Transmit FIFO fill level |
| tx_req | input | 1 | Framer needs a byte |
| tx_done | input | 1 | Framer shifted out the last bit |
| tx_byte_vld | output | 1 | Byte granted to the framer |
| tx_byte | output | 8 | Granted byte |
| tx_last | output | 1 | Granted byte ends the frame |
| tx_abort | output | 1 | Framer must send an abort |
| tx_locked | output | 1 | Transmit side locked after underrun |
| sts_rd | input | 1 | Host reads and clears status |
| sts_q | output | 4 | Status register |
| mask_wr | input | 1 | Load the mask |
| mask_wdata | input | 4 | Mask value, 1 hides a bit |
| irq | output | 1 | Interrupt request |

## Verification
Receive frames of three lengths separate the pool cases:
- 40 bytes: a pool event at byte 32.
- Exactly 32 bytes, the last one completing the pool: no event.
- 70 bytes without pops: pools at 32 and 64, then six losses. Reception then resumes after space is freed, and the frame ends flagged as lossy. A short clean frame follows and shows that the frame flag resets.

A pool event placed in the same cycle as a status read checks that the event survives the clear. On the transmit side, a three-byte message with a message end shows the grant and last-byte marking. An unterminated message shows the underrun and the lockout, with pushes, requests and done pulses ignored until a read. Done pulses are issued with `hdlc_mode`=1 and `hdlc_mode`=0, and with and without a mask bit set.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
    localparam int STS_W  = 4;
    localparam int B_POOL = 0;
    localparam int B_UDR  = 1;
    localparam int B_ALLS = 2;
    localparam int B_OVF  = 3;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_LOCKED
    } tx_state_t;

    typedef enum logic {
        RX_GAP,
        RX_FRAME
    } rx_state_t;
endpackage

// File: rtl/hfs_fifo.sv
module hfs_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FIFO_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
endmodule

// File: rtl/hfs_rx_track.sv
module hfs_rx_track
    import hfs_pkg::*;
#(
    parameter  int POOL = 32,
    localparam int PW   = $clog2(POOL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    input  logic byte_last,
    input  logic fifo_full,
    output logic store,
    output logic ev_pool,
    output logic ev_ovf,
    output logic fstat_vld,
    output logic fstat_ovf
);
    rx_state_t     st, st_n;
    logic [PW-1:0] cnt;
    logic          frm_ovf;
    logic          lost, hit, ends;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_GAP;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            RX_GAP:   if (byte_vld && !byte_last) st_n = RX_FRAME;
            RX_FRAME: if (byte_vld && byte_last)  st_n = RX_GAP;
            default:  st_n = RX_GAP;
        endcase
    end

    // outputs
    always_comb begin
        ends    = byte_vld && byte_last;
        store   = byte_vld && !fifo_full;
        lost    = byte_vld && fifo_full;
        hit     = store && (cnt == PW'(POOL - 1));
        ev_pool = hit && !byte_last;
        ev_ovf  = lost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            frm_ovf   <= 1'b0;
            fstat_vld <= 1'b0;
            fstat_ovf <= 1'b0;
        end else begin
            fstat_vld <= ends;
            if (ends) begin
                fstat_ovf <= frm_ovf | lost;
                frm_ovf   <= 1'b0;
                cnt       <= '0;
            end else begin
                if (lost) frm_ovf <= 1'b1;
                if (hit)        cnt <= '0;
                else if (store) cnt <= cnt + PW'(1);
            end
        end
    end

    AST_GAP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_GAP) |-> (cnt == '0 && !frm_ovf)); // R2
endmodule

// File: rtl/hfs_tx_ctrl.sv
module hfs_tx_ctrl
    import hfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic done,
    input  logic hdlc_mode,
    input  logic msg_end,
    input  logic push,
    input  logic fifo_empty,
    input  logic fifo_one,
    input  logic sts_rd,
    output logic pop,
    output logic last,
    output logic abort,
    output logic flush,
    output logic push_ok,
    output logic locked,
    output logic ev_udr,
    output logic ev_alls
);
    tx_state_t st, st_n;
    logic      msg_pend;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            TX_IDLE: begin
                if (abort)            st_n = TX_LOCKED;
                else if (pop && !last) st_n = TX_SEND;
            end
            TX_SEND: begin
                if (abort)     st_n = TX_LOCKED;
                else if (last) st_n = TX_IDLE;
            end
            TX_LOCKED: if (sts_rd) st_n = TX_IDLE;
            default:   st_n = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        locked  = (st == TX_LOCKED);
        pop     = !locked && req && !fifo_empty;
        last    = pop && fifo_one && msg_pend;
        abort   = !locked && req && fifo_empty && !msg_pend;
        flush   = abort || locked;
        push_ok = push && !flush;
        ev_udr  = abort;
        ev_alls = done && hdlc_mode && fifo_empty && !locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            msg_pend <= 1'b0;
        else if (abort || locked)              msg_pend <= 1'b0;
        else if (msg_end)                      msg_pend <= 1'b1;
        else if (last || (req && fifo_empty))  msg_pend <= 1'b0;
    end

    AST_UNDERRUN_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (locked && fifo_empty)); // R6
    AST_LOCK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_LOCKED) |-> fifo_empty); // R7
endmodule

// File: rtl/hdlc_fifo_stat.sv
module hdlc_fifo_stat
    import hfs_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int POOL  = 32,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdlc_mode,
    input  logic             rx_byte_vld,
    input  logic             rx_byte_last,
    input  logic [7:0]       rx_byte,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic             rx_empty,
    output logic [LW-1:0]    rx_level,
    output logic             rx_fstat_vld,
    output logic             rx_fstat_ovf,
    input  logic             tx_push,
    input  logic [7:0]       tx_wdata,
    input  logic             tx_msg_end,
    output logic             tx_full,
    output logic             tx_empty,
    output logic [LW-1:0]    tx_level,
    input  logic             tx_req,
    input  logic             tx_done,
    output logic             tx_byte_vld,
    output logic [7:0]       tx_byte,
    output logic             tx_last,
    output logic             tx_abort,
    output logic             tx_locked,
    input  logic             sts_rd,
    output logic [STS_W-1:0] sts_q,
    input  logic             mask_wr,
    input  logic [STS_W-1:0] mask_wdata,
    output logic             irq
);
    logic             rx_full, rx_store;
    logic             ev_pool, ev_ovf, ev_udr, ev_alls;
    logic             tx_flush, tx_push_ok;
    logic [STS_W-1:0] sts, mask, ev;

    hfs_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(rx_store), .wdata(rx_byte), .pop(rx_pop),
        .rdata(rx_data), .count(rx_level), .full(rx_full), .empty(rx_empty)
    );

    hfs_rx_track #(.POOL(POOL)) u_rx_track (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(rx_byte_vld), .byte_last(rx_byte_last), .fifo_full(rx_full),
        .store(rx_store), .ev_pool(ev_pool), .ev_ovf(ev_ovf),
        .fstat_vld(rx_fstat_vld), .fstat_ovf(rx_fstat_ovf)
    );

    hfs_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push_ok), .wdata(tx_wdata), .pop(tx_byte_vld),
        .rdata(tx_byte), .count(tx_level), .full(tx_full), .empty(tx_empty)
    );

    hfs_tx_ctrl u_tx_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req(tx_req), .done(tx_done), .hdlc_mode(hdlc_mode),
        .msg_end(tx_msg_end), .push(tx_push),
        .fifo_empty(tx_empty), .fifo_one(tx_level == LW'(1)),
        .sts_rd(sts_rd),
        .pop(tx_byte_vld), .last(tx_last), .abort(tx_abort),
        .flush(tx_flush), .push_ok(tx_push_ok), .locked(tx_locked),
        .ev_udr(ev_udr), .ev_alls(ev_alls)
    );

    always_comb begin
        ev         = '0;
        ev[B_POOL] = ev_pool;
        ev[B_UDR]  = ev_udr;
        ev[B_ALLS] = ev_alls;
        ev[B_OVF]  = ev_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts  <= '0;
            mask <= '0;
        end else begin
            sts <= (sts & ~{STS_W{sts_rd}}) | ev;
            if (mask_wr) mask <= mask_wdata;
        end
    end

    assign sts_q = sts;
    assign irq   = |(sts & ~mask);

    AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_vld && rx_full) |=> sts[B_OVF]); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !rx_byte_vld && !tx_req && !tx_done) |=> (sts == '0)); // R1
endmodule

// File: tb/hdlc_fifo_stat_bench.sv
module hdlc_fifo_stat_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdlc_mode = 1'b1;
    logic       rx_byte_vld = 0, rx_byte_last = 0, rx_pop = 0;
    logic [7:0] rx_byte = 0, tx_wdata = 0;
    logic       tx_push = 0, tx_msg_end = 0, tx_req = 0, tx_done = 0;
    logic       sts_rd = 0, mask_wr = 0;
    logic [3:0] mask_wdata = 0;
    logic [7:0] rx_data, tx_byte;
    logic [6:0] rx_level, tx_level;
    logic       rx_empty, rx_fstat_vld, rx_fstat_ovf, tx_full, tx_empty;
    logic       tx_byte_vld, tx_last, tx_abort, tx_locked, irq;
    logic [3:0] sts_q;

    always #10 clk = ~clk;

    hdlc_fifo_stat u_hdlc_fifo_stat (
        .clk(clk), .rst_n(rst_n), .hdlc_mode(hdlc_mode),
        .rx_byte_vld(rx_byte_vld), .rx_byte_last(rx_byte_last), .rx_byte(rx_byte),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_level(rx_level),
        .rx_fstat_vld(rx_fstat_vld), .rx_fstat_ovf(rx_fstat_ovf),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_msg_end(tx_msg_end),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level),
        .tx_req(tx_req), .tx_done(tx_done), .tx_byte_vld(tx_byte_vld),
        .tx_byte(tx_byte), .tx_last(tx_last), .tx_abort(tx_abort),
        .tx_locked(tx_locked), .sts_rd(sts_rd), .sts_q(sts_q),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq(irq)
    );

    // reference model state
    int       rxq[$];
    int       txq[$];
    bit [3:0] m_sts, m_mask;
    bit       m_lock, m_pend, m_frmovf, m_fvld, m_fovf;
    int       m_cnt;
    int       n_chk, n_fail;
    bit       finished;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit g, l, a;
        int tsz;
        tsz = txq.size();
        g = !m_lock && tx_req && tsz > 0;
        l = g && tsz == 1 && m_pend;
        a = !m_lock && tx_req && tsz == 0 && !m_pend;
        chk(rx_level == rxq.size(), "R3", "rx_level", rx_level, rxq.size());
        chk(rx_empty == (rxq.size() == 0), "R3", "rx_empty", rx_empty, rxq.size() == 0);
        if (rxq.size() > 0) chk(rx_data == rxq[0], "R3", "rx_data", rx_data, rxq[0]);
        chk(tx_level == tsz, "R7", "tx_level", tx_level, tsz);
        chk(tx_full == (tsz == 64), "R7", "tx_full", tx_full, tsz == 64);
        chk(tx_byte_vld == g, "R5", "tx_byte_vld", tx_byte_vld, g);
        if (g) chk(tx_byte == txq[0], "R5", "tx_byte", tx_byte, txq[0]);
        chk(tx_last == l, "R5", "tx_last", tx_last, l);
        chk(tx_abort == a, "R6", "tx_abort", tx_abort, a);
        chk(tx_locked == m_lock, "R7", "tx_locked", tx_locked, m_lock);
        chk(sts_q == m_sts, "R1", "sts_q", sts_q, m_sts);
        chk(irq == |(m_sts & ~m_mask), "R9", "irq", irq, |(m_sts & ~m_mask));
        chk(rx_fstat_vld == m_fvld, "R4", "rx_fstat_vld", rx_fstat_vld, m_fvld);
        if (m_fvld) chk(rx_fstat_ovf == m_fovf, "R4", "rx_fstat_ovf", rx_fstat_ovf, m_fovf);
    endtask

    task automatic model_step();
        bit [3:0] ev = '0;
        bit lost = 0, g, l, a;
        int rsz = rxq.size();
        int tsz = txq.size();
        if (rx_pop && rsz > 0) void'(rxq.pop_front());
        if (rx_byte_vld) begin
            if (rsz >= 64) begin
                lost = 1; ev[3] = 1;
            end else begin
                rxq.push_back(int'(rx_byte));
                m_cnt++;
                if (m_cnt == 32) begin
                    m_cnt = 0;
                    if (!rx_byte_last) ev[0] = 1;
                end
            end
        end
        m_fvld = rx_byte_vld && rx_byte_last;
        if (m_fvld) begin
            m_fovf = m_frmovf | lost; m_frmovf = 0; m_cnt = 0;
        end else if (lost) m_frmovf = 1;
        g = !m_lock && tx_req && tsz > 0;
        l = g && tsz == 1 && m_pend;
        a = !m_lock && tx_req && tsz == 0 && !m_pend;
        if (tx_done && hdlc_mode && !m_lock && tsz == 0) ev[2] = 1;
        if (m_lock) begin
            m_pend = 0; txq.delete();
            if (sts_rd) m_lock = 0;
        end else if (a) begin
            ev[1] = 1; txq.delete(); m_lock = 1; m_pend = 0;
        end else begin
            if (g) void'(txq.pop_front());
            if (tx_push && tsz < 64) txq.push_back(int'(tx_wdata));
            if (tx_msg_end) m_pend = 1;
            else if (l || (tx_req && tsz == 0)) m_pend = 0;
        end
        m_sts = (sts_rd ? 4'b0 : m_sts) | ev;
        if (mask_wr) m_mask = mask_wdata;
    endtask

    task automatic tick();
        #1;
        compare();
        model_step();
        @(posedge clk);
        @(negedge clk);
        rx_byte_vld = 0; rx_byte_last = 0; rx_pop = 0;
        tx_push = 0; tx_msg_end = 0; tx_req = 0; tx_done = 0;
        sts_rd = 0; mask_wr = 0;
    endtask

    task automatic rx_b(input int v, input bit last);
        rx_byte_vld = 1; rx_byte = 8'(v); rx_byte_last = last;
        tick();
    endtask

    task automatic drain_rx();
        while (rxq.size() > 0) begin rx_pop = 1; tick(); end
    endtask

    task automatic rd_expect(input bit [3:0] exp, input string req);
        sts_rd = 1;
        #1 chk(sts_q == exp, req, "status read", sts_q, exp);
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(sts_q == 0 && irq == 0, "R10", "status/irq at reset", {sts_q, irq}, 0);
        chk(rx_empty && tx_empty, "R10", "fifos empty at reset", {rx_empty, tx_empty}, 3);
        chk(!tx_locked && !rx_fstat_vld, "R10", "lock/fstat at reset", {tx_locked, rx_fstat_vld}, 0);
        rst_n = 1;
        tick();

        // R2: 40-byte frame, pool at byte 32
        for (int i = 1; i <= 40; i++) rx_b(i, i == 40);
        rd_expect(4'b0001, "R2");
        drain_rx();
        // R2: pool completed by the last byte raises nothing
        for (int i = 1; i <= 32; i++) rx_b(100 + i, i == 32);
        rd_expect(4'b0000, "R2");
        drain_rx();

        // R3/R4: 70 bytes without pops, then resume after space frees
        for (int i = 1; i <= 70; i++) rx_b(i, 1'b0);
        chk(rx_level == 64, "R3", "rx_level after overflow", rx_level, 64);
        for (int i = 0; i < 5; i++) begin rx_pop = 1; tick(); end
        rx_b(201, 0); rx_b(202, 0); rx_b(203, 1);
        #1 chk(rx_fstat_vld && rx_fstat_ovf, "R4", "lossy frame status",
               {rx_fstat_vld, rx_fstat_ovf}, 3);
        rd_expect(4'b1001, "R3");
        drain_rx();
        for (int i = 1; i <= 5; i++) rx_b(i, i == 5);
        #1 chk(rx_fstat_vld && !rx_fstat_ovf, "R4", "clean frame status",
               {rx_fstat_vld, rx_fstat_ovf}, 2);
        drain_rx();

        // R1: event in the read cycle survives the clear
        for (int i = 1; i <= 31; i++) rx_b(i, 0);
        rx_byte_vld = 1; rx_byte = 8'h20; sts_rd = 1;
        #1 chk(sts_q == 4'b0000, "R1", "read during event", sts_q, 0);
        tick();
        rd_expect(4'b0001, "R1");
        rx_b(8'h55, 1);
        drain_rx();

        // R5/R8: three-byte message
        hdlc_mode = 1;
        foreach (txq[i]) ; // no-op
        tx_push = 1; tx_wdata = 8'hA1; tick();
        tx_push = 1; tx_wdata = 8'hA2; tick();
        tx_push = 1; tx_wdata = 8'hA3; tx_msg_end = 1; tick();
        tx_req = 1; tick();
        tx_req = 1; tick();
        tx_req = 1;
        #1 chk(tx_byte_vld && tx_last && tx_byte == 8'hA3, "R5", "final grant",
               {tx_byte_vld, tx_last, tx_byte}, {2'b11, 8'hA3});
        tick();
        tx_done = 1; tick();
        rd_expect(4'b0100, "R8");
        hdlc_mode = 0;
        tx_done = 1; tick();
        rd_expect(4'b0000, "R8");
        hdlc_mode = 1;

        // R6/R7: underrun and lockout
        tx_push = 1; tx_wdata = 8'hB1; tick();
        tx_push = 1; tx_wdata = 8'hB2; tick();
        tx_req = 1; tick();
        tx_req = 1; tick();
        tx_req = 1;
        #1 chk(tx_abort == 1, "R6", "abort on empty", tx_abort, 1);
        tick();
        chk(tx_locked == 1, "R7", "locked after abort", tx_locked, 1);
        for (int i = 0; i < 3; i++) begin tx_push = 1; tx_wdata = 8'(i); tick(); end
        tx_req = 1; tx_done = 1; tx_msg_end = 1;
        #1 chk(!tx_byte_vld && !tx_abort, "R7", "request ignored when locked",
               {tx_byte_vld, tx_abort}, 0);
        tick();
        chk(tx_empty == 1, "R7", "pushes ignored when locked", tx_empty, 1);
        rd_expect(4'b0010, "R6");
        chk(tx_locked == 0, "R7", "unlocked after read", tx_locked, 0);
        tx_push = 1; tx_wdata = 8'hC1; tx_msg_end = 1; tick();
        tx_req = 1;
        #1 chk(tx_byte_vld && tx_last, "R7", "transmit resumes", {tx_byte_vld, tx_last}, 3);
        tick();

        // R9: masked bit still sets, hidden from irq
        mask_wr = 1; mask_wdata = 4'b0100; tick();
        tx_done = 1; tick();
        chk(sts_q == 4'b0100 && irq == 0, "R9", "masked event", {sts_q, irq}, 8);
        mask_wr = 1; mask_wdata = 4'b0000; tick();
        chk(irq == 1, "R9", "unmasked irq", irq, 1);
        rd_expect(4'b0100, "R9");
        tick();

        finished = 1;
        summary();
        $finish;
    end
endmodule